// File: doc/BRIEF.md
# Branch Outcome and Next-PC Resolver

This block resolves one jump-class instruction per cycle. It receives the 8-bit opcode, the two register values, the sign-extended immediate, a 16-bit signed slot offset and the current program counter. The PC counts 8-byte instruction slots. From these it decides whether the branch is taken and produces the next PC. Call and return share the jump opcode space and leave the block as separate strobes. A call also carries the immediate as a function index. The results are registered, so they appear one clock after the instruction is presented.

A conditional branch names only a taken target, PC + 1 + offset. When the condition is false, the next PC is simply the following slot. Two classes are decoded. One compares the full 64-bit operands. The other compares only the low 32 bits, and there the signed relations use bit 31 as the sign. Encodings that make no sense raise an illegal flag instead of moving the PC. The called function and any stack handling belong to other blocks.

Top module: `br_resolve_unit`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid`, `taken`, `call_stb`, `exit_stb` and `illegal` are 0, and `next_pc` and `call_idx` are 0.
- R2: An instruction sampled with `in_valid` high produces its results on the next rising edge, together with `out_valid` = 1. A cycle with `in_valid` low yields `out_valid`, `taken`, `call_stb`, `exit_stb` and `illegal` all 0 on the next edge, whatever the opcode, and `next_pc` and `call_idx` keep their previous values.
- R3: A legal conditional branch whose condition is false gives `taken` = 0 and `next_pc` = `pc` + 1.
- R4: A taken branch gives `taken` = 1 and `next_pc` = `pc` + 1 + sign-extended `offset`, with the sum wrapping modulo 2^PCW.
- R5: Opcode bit 3 picks the second comparand: 1 selects `src_val`, 0 selects `imm`. The first comparand is always `dst_val`.
- R6: Opcode bits 2:0 give the class. 3'b101 compares all 64 bits. 3'b110 compares only bits 31:0, where the signed relations treat bit 31 as the sign.
- R7: Opcode bits 7:4 give the relation, equality or unsigned. 0x1 is taken when the values are equal and 0x5 when they differ. 0x2 is taken when a > b, 0x3 when a >= b, 0xA when a < b and 0xB when a <= b, all unsigned.
- R8: The signed relations are 0x6 (a > b), 0x7 (a >= b), 0xC (a < b) and 0xD (a <= b), all in two's complement.
- R9: Relation 0x4 is taken when the bitwise AND of the two comparands is nonzero.
- R10: Relation 0x0 in class 3'b101 is taken unconditionally, with the target of R4.
- R11: Relation 0x8 in class 3'b101 pulses `call_stb` and sets `call_idx` = `imm`[31:0], `next_pc` = `pc` + 1 and `taken` = 0.
- R12: Relation 0x9 in class 3'b101 pulses `exit_stb` with `next_pc` = `pc` and `taken` = 0.
- R13: Relations 0x0, 0x8 and 0x9 in class 3'b110, relations 0xE and 0xF, and any class other than 3'b101 or 3'b110 set `illegal` = 1 with `next_pc` = `pc`. In these cases `taken`, `call_stb` and `exit_stb` stay 0. At most one of `taken`, `call_stb`, `exit_stb` and `illegal` is ever 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction present this cycle |
| opcode | input | 8 | Relation [7:4], source select [3], class [2:0] |
| dst_val | input | DW | First comparand (destination register) |
| src_val | input | DW | Register second comparand |
| imm | input | DW | Sign-extended immediate |
| offset | input | 16 | Signed branch offset in slots |
| pc | input | PCW | Current slot address |
| out_valid | output | 1 | Result registered for a presented instruction |
| next_pc | output | PCW | Resolved next slot address |
| taken | output | 1 | Branch taken |
| call_stb | output | 1 | Call request pulse |
| call_idx | output | IDXW | Function index carried by a call |
| exit_stb | output | 1 | Return request pulse |
| illegal | output | 1 | Illegal encoding |

## Verification
Every result is due exactly one rising edge after the cycle in which `in_valid` was sampled high. The bench drives inputs on the falling edge and drops `in_valid` on the following falling edge. It reads the outputs at that same falling edge, half a period after the registering edge. The idle behaviour is checked one falling edge later still. By then the cleared valid has been registered, so the block must show the strobes low while `next_pc` and `call_idx` hold.

// File: rtl/br_pkg.sv
package br_pkg;

    localparam logic [2:0] CLS_WIDE   = 3'b101;
    localparam logic [2:0] CLS_NARROW = 3'b110;

    typedef enum logic [3:0] {
        OP_ALWAYS = 4'h0,
        OP_EQ     = 4'h1,
        OP_UGT    = 4'h2,
        OP_UGE    = 4'h3,
        OP_ANY    = 4'h4,
        OP_NE     = 4'h5,
        OP_SGT    = 4'h6,
        OP_SGE    = 4'h7,
        OP_CALL   = 4'h8,
        OP_RET    = 4'h9,
        OP_ULT    = 4'hA,
        OP_ULE    = 4'hB,
        OP_SLT    = 4'hC,
        OP_SLE    = 4'hD
    } br_op_e;

endpackage

// File: rtl/br_operand_sel.sv
module br_operand_sel #(
    parameter int DW = 64
) (
    input  logic [DW-1:0] dst_i,
    input  logic [DW-1:0] src_i,
    input  logic [DW-1:0] imm_i,
    input  logic          use_src_i,
    output logic [DW-1:0] a_o,
    output logic [DW-1:0] b_o
);
    always_comb begin
        a_o = dst_i;
        b_o = use_src_i ? src_i : imm_i;
    end
endmodule

// File: rtl/br_compare.sv
module br_compare
    import br_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [3:0]   rel_i,
    output logic         hit_o
);
    logic eq;
    logic ult;
    logic slt;

    always_comb begin
        eq  = (a_i == b_i);
        ult = (a_i < b_i);
        slt = ($signed(a_i) < $signed(b_i));
        case (rel_i)
            OP_EQ:   hit_o = eq;
            OP_NE:   hit_o = !eq;
            OP_UGT:  hit_o = !ult && !eq;
            OP_UGE:  hit_o = !ult;
            OP_ULT:  hit_o = ult;
            OP_ULE:  hit_o = ult || eq;
            OP_SGT:  hit_o = !slt && !eq;
            OP_SGE:  hit_o = !slt;
            OP_SLT:  hit_o = slt;
            OP_SLE:  hit_o = slt || eq;
            OP_ANY:  hit_o = |(a_i & b_i);
            default: hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/br_target.sv
module br_target #(
    parameter int PCW = 32,
    parameter int OFW = 16
) (
    input  logic [PCW-1:0] pc_i,
    input  logic [OFW-1:0] off_i,
    output logic [PCW-1:0] seq_o,
    output logic [PCW-1:0] tgt_o
);
    localparam int EXTW = PCW - OFW;

    logic [PCW-1:0] off_ext;

    always_comb begin
        off_ext = {{EXTW{off_i[OFW-1]}}, off_i};
        seq_o   = pc_i + PCW'(1);
        tgt_o   = seq_o + off_ext;
    end
endmodule

// File: rtl/br_resolve_unit.sv
module br_resolve_unit
    import br_pkg::*;
#(
    parameter int DW   = 64,
    parameter int PCW  = 32,
    parameter int OFW  = 16,
    parameter int IDXW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [7:0]      opcode,
    input  logic [DW-1:0]   dst_val,
    input  logic [DW-1:0]   src_val,
    input  logic [DW-1:0]   imm,
    input  logic [OFW-1:0]  offset,
    input  logic [PCW-1:0]  pc,
    output logic            out_valid,
    output logic [PCW-1:0]  next_pc,
    output logic            taken,
    output logic            call_stb,
    output logic [IDXW-1:0] call_idx,
    output logic            exit_stb,
    output logic            illegal
);
    localparam int HALF   = DW / 2;
    localparam int NLANES = 2;

    typedef struct packed {
        logic            vld;
        logic            taken;
        logic            call;
        logic            ext;
        logic            ill;
        logic [PCW-1:0]  npc;
        logic [IDXW-1:0] idx;
    } res_t;

    res_t res_d, res_q;

    logic [DW-1:0]     op_a, op_b;
    logic [NLANES-1:0] lane_hit;
    logic [PCW-1:0]    seq_pc, tgt_pc;

    br_operand_sel #(.DW(DW)) u_sel (
        .dst_i     (dst_val),
        .src_i     (src_val),
        .imm_i     (imm),
        .use_src_i (opcode[3]),
        .a_o       (op_a),
        .b_o       (op_b)
    );

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        localparam int LW = (g == 0) ? DW : HALF;
        br_compare #(.W(LW)) u_cmp (
            .a_i   (op_a[LW-1:0]),
            .b_i   (op_b[LW-1:0]),
            .rel_i (opcode[7:4]),
            .hit_o (lane_hit[g])
        );
    end

    br_target #(.PCW(PCW), .OFW(OFW)) u_tgt (
        .pc_i  (pc),
        .off_i (offset),
        .seq_o (seq_pc),
        .tgt_o (tgt_pc)
    );

    logic [2:0] cls;
    logic [3:0] rel;
    logic       wide, jump_cls, special, undef_rel, bad, hit;

    always_comb begin
        cls       = opcode[2:0];
        rel       = opcode[7:4];
        wide      = (cls == CLS_WIDE);
        jump_cls  = wide || (cls == CLS_NARROW);
        special   = (rel == OP_ALWAYS) || (rel == OP_CALL) || (rel == OP_RET);
        undef_rel = (rel >= 4'hE);
        bad       = !jump_cls || undef_rel || (special && !wide);
        hit       = wide ? lane_hit[0] : lane_hit[1];

        res_d       = res_q;
        res_d.vld   = 1'b0;
        res_d.taken = 1'b0;
        res_d.call  = 1'b0;
        res_d.ext   = 1'b0;
        res_d.ill   = 1'b0;

        if (in_valid) begin
            res_d.vld = 1'b1;
            if (bad) begin
                res_d.ill = 1'b1;
                res_d.npc = pc;
            end else begin
                case (rel)
                    OP_ALWAYS: begin
                        res_d.taken = 1'b1;
                        res_d.npc   = tgt_pc;
                    end
                    OP_CALL: begin
                        res_d.call = 1'b1;
                        res_d.idx  = imm[IDXW-1:0];
                        res_d.npc  = seq_pc;
                    end
                    OP_RET: begin
                        res_d.ext = 1'b1;
                        res_d.npc = pc;
                    end
                    default: begin
                        res_d.taken = hit;
                        res_d.npc   = hit ? tgt_pc : seq_pc;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.vld;
    assign next_pc   = res_q.npc;
    assign taken     = res_q.taken;
    assign call_stb  = res_q.call;
    assign call_idx  = res_q.idx;
    assign exit_stb  = res_q.ext;
    assign illegal   = res_q.ill;

endmodule

// File: rtl/br_resolve_chk.sv
module br_resolve_chk #(
    parameter int DW   = 64,
    parameter int PCW  = 32,
    parameter int OFW  = 16,
    parameter int IDXW = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [7:0]      opcode,
    input logic [DW-1:0]   imm,
    input logic [PCW-1:0]  pc,
    input logic            out_valid,
    input logic [PCW-1:0]  next_pc,
    input logic            taken,
    input logic            call_stb,
    input logic [IDXW-1:0] call_idx,
    input logic            exit_stb,
    input logic            illegal
);
    assert_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({taken, call_stb, exit_stb, illegal}));

    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !taken && !call_stb && !exit_stb && !illegal);

    assert_fallthrough_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !taken && !exit_stb && !illegal && !call_stb)
            |-> next_pc == PCW'($past(pc) + PCW'(1)));

    assert_call_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 8'h85)
            |=> call_stb && call_idx == $past(imm[IDXW-1:0]));

    assert_exit_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 8'h95) |=> exit_stb && next_pc == $past(pc));

    assert_narrow_always_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 8'h06) |=> illegal && !taken);
endmodule

bind br_resolve_unit br_resolve_chk #(
    .DW(DW), .PCW(PCW), .OFW(OFW), .IDXW(IDXW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opcode    (opcode),
    .imm       (imm),
    .pc        (pc),
    .out_valid (out_valid),
    .next_pc   (next_pc),
    .taken     (taken),
    .call_stb  (call_stb),
    .call_idx  (call_idx),
    .exit_stb  (exit_stb),
    .illegal   (illegal)
);

// File: tb/tb_br_resolve_unit.sv
module tb_br_resolve_unit;
    localparam int DW = 64;
    localparam int PCW = 32;
    localparam int NV = 26;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [7:0]      opcode = '0;
    logic [DW-1:0]   dst_val = '0, src_val = '0, imm = '0;
    logic [15:0]     offset = '0;
    logic [PCW-1:0]  pc = '0;
    logic            out_valid, taken, call_stb, exit_stb, illegal;
    logic [PCW-1:0]  next_pc;
    logic [31:0]     call_idx;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    br_resolve_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .dst_val(dst_val), .src_val(src_val), .imm(imm), .offset(offset), .pc(pc),
        .out_valid(out_valid), .next_pc(next_pc), .taken(taken), .call_stb(call_stb),
        .call_idx(call_idx), .exit_stb(exit_stb), .illegal(illegal)
    );

    typedef struct packed {
        logic [7:0]  op;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] im;
        logic [15:0] off;
        logic [31:0] pcv;
        logic [31:0] npc;
        logic [3:0]  fl;   // taken, call, exit, illegal
        logic [7:0]  req;
    } vec_t;

    localparam logic [63:0] M1 = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] M5 = 64'hFFFF_FFFF_FFFF_FFFB;
    localparam logic [63:0] M3 = 64'hFFFF_FFFF_FFFF_FFFD;

    localparam vec_t VEC [NV] = '{
        {8'h1D, 64'd5, 64'd5, 64'd0, 16'd10, 32'd100, 32'd111, 4'b1000, 8'd5},  // R5 R7 reg eq
        {8'h15, 64'd5, 64'd5, 64'd6, 16'd10, 32'd100, 32'd101, 4'b0000, 8'd5},  // R5 imm used
        {8'h55, 64'd5, 64'd5, 64'd6, 16'd10, 32'd100, 32'd111, 4'b1000, 8'd7},  // R7 ne
        {8'h2D, M1,    64'd1, 64'd0, 16'd10, 32'd100, 32'd111, 4'b1000, 8'd7},  // R7 ugt
        {8'h6D, M1,    64'd1, 64'd0, 16'd10, 32'd100, 32'd101, 4'b0000, 8'd8},  // R8 sgt
        {8'hCD, M1,    64'd1, 64'd0, 16'd10, 32'd100, 32'd111, 4'b1000, 8'd8},  // R8 slt
        {8'h3D, 64'd7, 64'd7, 64'd0, 16'd10, 32'd100, 32'd111, 4'b1000, 8'd7},  // R7 uge
        {8'hB5, 64'd8, 64'd0, 64'd7, 16'd10, 32'd100, 32'd101, 4'b0000, 8'd3},  // R3 ule
        {8'hA5, 64'd3, 64'd0, 64'd7, 16'd10, 32'd100, 32'd111, 4'b1000, 8'd7},  // R7 ult
        {8'h75, M5,    64'd0, M5,    16'd10, 32'd100, 32'd111, 4'b1000, 8'd8},  // R8 sge
        {8'hDD, 64'd2, M3,    64'd0, 16'd10, 32'd100, 32'd101, 4'b0000, 8'd8},  // R8 sle
        {8'h45, 64'hF0, 64'd0, 64'h0F, 16'd10, 32'd100, 32'd101, 4'b0000, 8'd9}, // R9 no overlap
        {8'h4D, 64'hF0, 64'h10, 64'd0, 16'd10, 32'd100, 32'd111, 4'b1000, 8'd9}, // R9 overlap
        {8'h1E, 64'h1_0000_0005, 64'h2_0000_0005, 64'd0, 16'd10, 32'd100, 32'd111, 4'b1000, 8'd6}, // R6
        {8'h1D, 64'h1_0000_0005, 64'h2_0000_0005, 64'd0, 16'd10, 32'd100, 32'd101, 4'b0000, 8'd6}, // R6
        {8'h6E, 64'h8000_0000, 64'd1, 64'd0, 16'd10, 32'd100, 32'd101, 4'b0000, 8'd6}, // R6 narrow sign
        {8'h6D, 64'h8000_0000, 64'd1, 64'd0, 16'd10, 32'd100, 32'd111, 4'b1000, 8'd6}, // R6 wide
        {8'h05, 64'd0, 64'd0, 64'd0, 16'hFFEC, 32'd100, 32'd81, 4'b1000, 8'd10}, // R10 R4 back
        {8'h85, 64'd0, 64'd0, 64'd42, 16'd10, 32'd100, 32'd101, 4'b0100, 8'd11}, // R11
        {8'h95, 64'd0, 64'd0, 64'd0, 16'd10, 32'd100, 32'd100, 4'b0010, 8'd12},  // R12
        {8'h06, 64'd0, 64'd0, 64'd0, 16'd10, 32'd100, 32'd100, 4'b0001, 8'd13},  // R13
        {8'h86, 64'd0, 64'd0, 64'd7, 16'd10, 32'd100, 32'd100, 4'b0001, 8'd13},  // R13
        {8'h96, 64'd0, 64'd0, 64'd0, 16'd10, 32'd100, 32'd100, 4'b0001, 8'd13},  // R13
        {8'hE5, 64'd0, 64'd0, 64'd0, 16'd10, 32'd100, 32'd100, 4'b0001, 8'd13},  // R13
        {8'h04, 64'd0, 64'd0, 64'd0, 16'd10, 32'd100, 32'd100, 4'b0001, 8'd13},  // R13
        {8'h05, 64'd0, 64'd0, 64'd0, 16'd1, 32'hFFFF_FFFE, 32'd0, 4'b1000, 8'd4} // R4 wrap
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input vec_t v, input logic vld);
        @(negedge clk);
        opcode = v.op; dst_val = v.a; src_val = v.b; imm = v.im;
        offset = v.off; pc = v.pcv; in_valid = vld;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1", {out_valid, taken, call_stb, exit_stb, illegal}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {out_valid, taken, call_stb, exit_stb, illegal}, 0);
        check("R1", next_pc, 0);
        check("R1", call_idx, 0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
            issue(VEC[i], 1'b1);
            check(tag, out_valid, 1);
            check(tag, next_pc, VEC[i].npc);
            check(tag, {taken, call_stb, exit_stb, illegal}, VEC[i].fl);
            if (VEC[i].fl[2]) check("R11 idx", call_idx, VEC[i].im[31:0]);
        end

        // R2: idle cycle after a call keeps next_pc and call_idx
        issue(VEC[18], 1'b1);
        @(negedge clk);
        check("R2 idle flags", {out_valid, taken, call_stb, exit_stb, illegal}, 0);
        check("R2 hold npc", next_pc, 101);
        check("R2 hold idx", call_idx, 42);

        // R2: a jump opcode without valid is ignored
        issue(VEC[17], 1'b0);
        check("R2 ignored", {out_valid, taken, call_stb, exit_stb, illegal}, 0);
        check("R2 ignored npc", next_pc, 101);

        // R11: new call index replaces old one
        issue('{op:8'h8D, a:64'd0, b:64'd0, im:64'hFFFF_FFFF_1234_5678, off:16'd0,
                pcv:32'd7, npc:32'd8, fl:4'b0100, req:8'd11}, 1'b1);
        check("R11 idx low", call_idx, 32'h1234_5678);
        check("R11 npc", next_pc, 8);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule